// File: doc/BRIEF.md
# Paged call/return sequencer

This block carries out a far subroutine call and the matching far return for a 16-bit processor whose 64KB local address space has a banked 16KB program window. An 8-bit page register picks which of 256 pages is visible through that window. The window occupies local addresses 0x8000 to 0xBFFF. On a call the block does four things in order. It keeps the current page in a holding register and installs the new page. It stacks the return address, then the old page. It then redirects the fetch address to the subroutine and asks for a fetch-queue refill. On a return it unstacks the page first and the return address second, then restores both.

The caller gives the new page and target in one of two ways: as immediate operands, or through a pointer into memory (the indirect variant). For the indirect variant the block reads memory itself before the call steps begin. Once a sequence starts it runs to its end. While it runs, the block blocks interrupt acceptance and ignores any further requests. The current fetch address is also translated into a physical address through the page window.

Top module: `paged_call_seq`

## Requirements
- R1: After reset, busy, done, irq_block, stk_we, stk_re and mem_rd_req are 0; page_o is 0x00; fetch_addr is 0x0000; sp_o is 0x0200.
- R2: A direct call (call_req=1, call_indirect=0) sampled while idle makes busy high for the next 4 cycles, with done high only in the 4th. From the 2nd of those cycles on, page_o shows call_page.
- R3: A call uses two stack writes, one per cycle, with the stack pointer decremented by 2 before each write. First the return address (cur_pc + instr_len) is written at SP-2. Then the old page is written at SP-4 in bits 7:0, with bits 15:8 zero. sp_o ends 4 lower.
- R4: In the cycle done is high after a call, fetch_addr equals the target and refill is high. done lasts exactly one cycle.
- R5: An indirect call (call_indirect=1) first reads memory at ptr_addr and takes bits 7:0 as the new page. It then reads memory at ptr_addr+1 and takes all 16 bits as the target. This adds 2 cycles, so done comes in the 6th busy cycle.
- R6: A return (ret_req=1) reads the page from stack address SP (bits 7:0), then the return address from SP+2. It ends with sp_o 4 higher, busy for 3 cycles and done in the 3rd. page_o and fetch_addr then hold the popped values.
- R7: call_req and ret_req that arrive while busy is high have no effect. irq_block equals busy, and busy falls in the cycle after done.
- R8: When fetch_addr[15:14] is 2'b10, phys_fetch is {page_o, fetch_addr[13:0]} and win_hit is 1. Otherwise phys_fetch is {6'b0, fetch_addr} and win_hit is 0.
- R9: When call_req and ret_req are both high while idle, the call is performed and the return request is dropped.
- R10: stk_we and stk_re are never high together, and both are 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Start a far call (sampled while idle) |
| call_indirect | input | 1 | Call operands come from memory via ptr_addr |
| ret_req | input | 1 | Start a far return (sampled while idle) |
| call_page | input | 8 | Immediate new page |
| call_target | input | 16 | Immediate subroutine address |
| ptr_addr | input | 16 | Pointer to page byte (ptr) and target word (ptr+1) |
| cur_pc | input | 16 | Address of the call instruction |
| instr_len | input | 3 | Length of the call instruction in bytes |
| mem_rd_req | output | 1 | Operand read strobe |
| mem_rd_addr | output | 16 | Operand read address |
| mem_rd_data | input | 16 | Operand read data, valid in the strobe cycle |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | 16 | Stack access address |
| stk_wdata | output | 16 | Stack write data |
| stk_rdata | input | 16 | Stack read data, valid in the strobe cycle |
| page_o | output | 8 | Current page register |
| sp_o | output | 16 | Current stack pointer |
| fetch_addr | output | 16 | Current local fetch address |
| phys_fetch | output | 22 | Translated fetch address |
| win_hit | output | 1 | fetch_addr lies in the page window |
| refill | output | 1 | Fetch-queue refill request (with done) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | New fetch address valid this cycle |
| irq_block | output | 1 | Interrupt acceptance blocked |

## Verification
The bench sweeps all 256 page values through calls, mixing direct and indirect operands. Returns are interleaved so that the stack nests up to 64 frames deep before it unwinds. A sequencer that swapped the push order, or stacked the new page rather than the old one, would restore the wrong page or jump to a page value on return. Getting the pre-decrement wrong would shift every frame by one word. Stray requests injected mid-sequence, and simultaneous call and return, show whether an extra sequence is queued or the wrong one wins: that shows up as a changed stack pointer or a late busy. Targets at 0x7FFF, 0x8000, 0xBFFF and 0xC000 expose an off-by-one in the window decode.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_RD_PG   = 4'd1,
    ST_RD_TGT  = 4'd2,
    ST_SWAP    = 4'd3,
    ST_PUSH_RA = 4'd4,
    ST_PUSH_PG = 4'd5,
    ST_POP_PG  = 4'd6,
    ST_POP_RA  = 4'd7,
    ST_FIN     = 4'd8
  } seq_st_e;

endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    call_req,
  input  logic    call_indirect,
  input  logic    ret_req,
  output seq_st_e state
);

  seq_st_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: begin
        if (call_req)     state_d = call_indirect ? ST_RD_PG : ST_SWAP;
        else if (ret_req) state_d = ST_POP_PG;
      end
      ST_RD_PG:   state_d = ST_RD_TGT;
      ST_RD_TGT:  state_d = ST_SWAP;
      ST_SWAP:    state_d = ST_PUSH_RA;
      ST_PUSH_RA: state_d = ST_PUSH_PG;
      ST_PUSH_PG: state_d = ST_FIN;
      ST_POP_PG:  state_d = ST_POP_RA;
      ST_POP_RA:  state_d = ST_FIN;
      ST_FIN:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  // R7: a started sequence never drops back to idle before its final step
  p_atomic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state != ST_FIN) |=> (state != ST_IDLE))
    else $error("sequence aborted before completion");

endmodule

// File: rtl/pcs_sp.sv
module pcs_sp #(
  parameter int          AW       = 16,
  parameter int          STEP     = 2,
  parameter logic [15:0] SP_RESET = 16'h0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] stk_addr
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] sp_d;
  logic          sp_en;

  always_comb begin
    sp_en = push | pop;
    sp_d  = sp_q;
    if (push)     sp_d = sp_q - STEP_V;
    else if (pop) sp_d = sp_q + STEP_V;
  end

  // pre-decrement for pushes, post-increment for pops
  assign stk_addr = push ? (sp_q - STEP_V) : sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= AW'(SP_RESET);
    else if (sp_en) sp_q <= sp_d;
  end

  p_push_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sp_q == $past(sp_q) - STEP_V))
    else $error("push did not lower the stack pointer by one step");

  p_pop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (sp_q == $past(sp_q) + STEP_V))
    else $error("pop did not raise the stack pointer by one step");

endmodule

// File: rtl/pcs_xlate.sv
module pcs_xlate #(
  parameter int AW      = 16,
  parameter int PAGE_W  = 8,
  parameter int WIN_W   = 14,
  parameter int WIN_SEL = 2
) (
  input  logic [AW-1:0]           laddr,
  input  logic [PAGE_W-1:0]       page,
  output logic                    hit,
  output logic [PAGE_W+WIN_W-1:0] paddr
);

  localparam int SEL_W  = AW - WIN_W;
  localparam int PHYS_W = PAGE_W + WIN_W;

  assign hit = (laddr[AW-1:WIN_W] == SEL_W'(WIN_SEL));

  generate
    if (PHYS_W > AW) begin : g_pad
      always_comb begin
        if (hit) paddr = {page, laddr[WIN_W-1:0]};
        else     paddr = {{(PHYS_W-AW){1'b0}}, laddr};
      end
    end else begin : g_trunc
      always_comb begin
        if (hit) paddr = {page, laddr[WIN_W-1:0]};
        else     paddr = laddr[PHYS_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/paged_call_seq.sv
module paged_call_seq
  import pcs_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          PAGE_W   = 8,
  parameter int          WIN_W    = 14,
  parameter int          WIN_SEL  = 2,
  parameter int          LEN_W    = 3,
  parameter int          STEP     = 2,
  parameter logic [15:0] SP_RESET = 16'h0200
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    call_req,
  input  logic                    call_indirect,
  input  logic                    ret_req,
  input  logic [PAGE_W-1:0]       call_page,
  input  logic [AW-1:0]           call_target,
  input  logic [AW-1:0]           ptr_addr,
  input  logic [AW-1:0]           cur_pc,
  input  logic [LEN_W-1:0]        instr_len,
  output logic                    mem_rd_req,
  output logic [AW-1:0]           mem_rd_addr,
  input  logic [AW-1:0]           mem_rd_data,
  output logic                    stk_we,
  output logic                    stk_re,
  output logic [AW-1:0]           stk_addr,
  output logic [AW-1:0]           stk_wdata,
  input  logic [AW-1:0]           stk_rdata,
  output logic [PAGE_W-1:0]       page_o,
  output logic [AW-1:0]           sp_o,
  output logic [AW-1:0]           fetch_addr,
  output logic [PAGE_W+WIN_W-1:0] phys_fetch,
  output logic                    win_hit,
  output logic                    refill,
  output logic                    busy,
  output logic                    done,
  output logic                    irq_block
);

  localparam logic [AW-1:0] ONE_V = AW'(1);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_s2, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_int_n = rst_s2;

  seq_st_e state;

  pcs_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .call_req      (call_req),
    .call_indirect (call_indirect),
    .ret_req       (ret_req),
    .state         (state)
  );

  logic push, pop;
  assign push = (state == ST_PUSH_RA) || (state == ST_PUSH_PG);
  assign pop  = (state == ST_POP_PG)  || (state == ST_POP_RA);

  pcs_sp #(.AW(AW), .STEP(STEP), .SP_RESET(SP_RESET)) u_sp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .push     (push),
    .pop      (pop),
    .sp_q     (sp_o),
    .stk_addr (stk_addr)
  );

  // datapath registers
  logic [PAGE_W-1:0] page_q, page_d;
  logic [PAGE_W-1:0] tmp_q,  tmp_d;
  logic [PAGE_W-1:0] npg_q,  npg_d;
  logic [AW-1:0]     tgt_q,  tgt_d;
  logic [AW-1:0]     ptr_q,  ptr_d;
  logic [AW-1:0]     ra_q,   ra_d;
  logic [AW-1:0]     fch_q,  fch_d;
  logic              op_en, page_en, tmp_en, fch_en;

  always_comb begin
    npg_d   = npg_q;
    tgt_d   = tgt_q;
    ptr_d   = ptr_q;
    ra_d    = ra_q;
    tmp_d   = tmp_q;
    page_d  = page_q;
    fch_d   = fch_q;
    op_en   = 1'b0;
    page_en = 1'b0;
    tmp_en  = 1'b0;
    fch_en  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        op_en = call_req;
        npg_d = call_page;
        tgt_d = call_target;
        ptr_d = ptr_addr;
        ra_d  = cur_pc + AW'(instr_len);
      end
      ST_RD_PG: begin
        op_en = 1'b1;
        npg_d = mem_rd_data[PAGE_W-1:0];
      end
      ST_RD_TGT: begin
        op_en = 1'b1;
        tgt_d = mem_rd_data;
      end
      ST_SWAP: begin
        tmp_en  = 1'b1;
        tmp_d   = page_q;
        page_en = 1'b1;
        page_d  = npg_q;
      end
      ST_PUSH_PG: begin
        fch_en = 1'b1;
        fch_d  = tgt_q;
      end
      ST_POP_PG: begin
        page_en = 1'b1;
        page_d  = stk_rdata[PAGE_W-1:0];
      end
      ST_POP_RA: begin
        fch_en = 1'b1;
        fch_d  = stk_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      npg_q  <= '0;
      tgt_q  <= '0;
      ptr_q  <= '0;
      ra_q   <= '0;
      tmp_q  <= '0;
      page_q <= '0;
      fch_q  <= '0;
    end else begin
      if (op_en) begin
        npg_q <= npg_d;
        tgt_q <= tgt_d;
        ptr_q <= ptr_d;
        ra_q  <= ra_d;
      end
      if (tmp_en)  tmp_q  <= tmp_d;
      if (page_en) page_q <= page_d;
      if (fch_en)  fch_q  <= fch_d;
    end
  end

  // memory and stack port strobes
  always_comb begin
    mem_rd_req  = (state == ST_RD_PG) || (state == ST_RD_TGT);
    mem_rd_addr = (state == ST_RD_TGT) ? (ptr_q + ONE_V) : ptr_q;
    stk_we      = push;
    stk_re      = pop;
    stk_wdata   = (state == ST_PUSH_PG) ? {{(AW-PAGE_W){1'b0}}, tmp_q} : ra_q;
  end

  assign page_o     = page_q;
  assign fetch_addr = fch_q;
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FIN);
  assign refill     = done;
  assign irq_block  = busy;

  pcs_xlate #(.AW(AW), .PAGE_W(PAGE_W), .WIN_W(WIN_W), .WIN_SEL(WIN_SEL)) u_xlate (
    .laddr (fch_q),
    .page  (page_q),
    .hit   (win_hit),
    .paddr (phys_fetch)
  );

  // R3: the second push carries the page that was current before the swap
  p_old_page_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_PUSH_PG) |-> (stk_wdata[PAGE_W-1:0] == $past(page_q, 2)))
    else $error("stacked page is not the pre-call page");

  // R4: done is a single-cycle pulse ending a busy stretch
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done)
    else $error("done held longer than one cycle");

  // R6: a return leaves the stack pointer two steps higher
  p_ret_sp_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && $past(state, 2) == ST_POP_PG) |-> (sp_o == $past(sp_o, 2) + STEP_V + STEP_V))
    else $error("return did not release two stack slots");

  // R10: one stack access per cycle, none outside a sequence
  p_one_stk_op_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(stk_we && stk_re))
    else $error("stack read and write in the same cycle");

  p_stk_quiet_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> (!stk_we && !stk_re && !mem_rd_req))
    else $error("stack or memory strobe while idle");

endmodule

// File: tb/tb_paged_call_seq.sv
module tb_paged_call_seq;

  logic        clk;
  logic        rst_n;
  logic        call_req, call_indirect, ret_req;
  logic [7:0]  call_page;
  logic [15:0] call_target, ptr_addr, cur_pc;
  logic [2:0]  instr_len;
  logic        mem_rd_req;
  logic [15:0] mem_rd_addr, mem_rd_data;
  logic        stk_we, stk_re;
  logic [15:0] stk_addr, stk_wdata, stk_rdata;
  logic [7:0]  page_o;
  logic [15:0] sp_o, fetch_addr;
  logic [21:0] phys_fetch;
  logic        win_hit, refill, busy, done, irq_block;

  paged_call_seq dut (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_indirect(call_indirect),
    .ret_req(ret_req), .call_page(call_page), .call_target(call_target),
    .ptr_addr(ptr_addr), .cur_pc(cur_pc), .instr_len(instr_len),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .stk_rdata(stk_rdata), .page_o(page_o), .sp_o(sp_o), .fetch_addr(fetch_addr),
    .phys_fetch(phys_fetch), .win_hit(win_hit), .refill(refill), .busy(busy),
    .done(done), .irq_block(irq_block)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // operand memory: each word is its address xor a fixed pattern
  assign mem_rd_data = mem_rd_addr ^ 16'h5A3C;

  // stack memory, word-addressed by stk_addr[8:1]
  logic [15:0] stk_mem [0:255];
  assign stk_rdata = stk_mem[stk_addr[8:1]];
  always @(posedge clk) if (stk_we) stk_mem[stk_addr[8:1]] <= stk_wdata;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench shadow of stacked frames
  logic [7:0]  sh_pg [0:127];
  logic [15:0] sh_ra [0:127];
  int          depth = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] exp_phys(input logic [15:0] a, input logic [7:0] p);
    if (a >= 16'h8000 && a <= 16'hBFFF) return {p, a[13:0]};
    return {6'd0, a};
  endfunction

  task automatic do_call(input bit ind, input logic [7:0] pg, input logic [15:0] tgt,
                         input logic [15:0] ptr, input logic [15:0] pc,
                         input logic [2:0] len, input bit noise, input bit both);
    logic [15:0] sp0, ra, e_tgt;
    logic [7:0]  pg0, e_pg;
    int k, e_k;
    sp0 = sp_o;
    pg0 = page_o;
    ra  = pc + {13'd0, len};
    e_pg  = ind ? ((ptr ^ 16'h5A3C) & 16'h00FF) : pg;
    e_tgt = ind ? ((ptr + 16'd1) ^ 16'h5A3C) : tgt;
    e_k   = ind ? 6 : 4;
    call_req = 1'b1; call_indirect = ind; ret_req = both;
    call_page = pg; call_target = tgt; ptr_addr = ptr; cur_pc = pc; instr_len = len;
    @(posedge clk);
    @(negedge clk);
    call_req = 1'b0; ret_req = 1'b0;
    chk("R7 irq_block during call", {31'd0, irq_block}, 32'd1);
    if (noise) begin call_req = 1'b1; ret_req = 1'b1; call_indirect = 1'b0; end
    k = 1;
    while (!done && k < 40) begin
      @(negedge clk);
      call_req = 1'b0; ret_req = 1'b0;
      chk("R2 busy while sequencing", {31'd0, busy}, 32'd1);
      if (!ind && k == 1) chk("R2 page loaded early", {24'd0, page_o}, {24'd0, e_pg});
      k++;
    end
    chk(ind ? "R5 indirect done cycle" : "R2 direct done cycle", k, e_k);
    chk("R2 page after call", {24'd0, page_o}, {24'd0, e_pg});
    chk(ind ? "R5 indirect target" : "R4 fetch target", {16'd0, fetch_addr}, {16'd0, e_tgt});
    chk("R4 refill with done", {31'd0, refill}, 32'd1);
    chk("R3 sp lowered by 4", {16'd0, sp_o}, {16'd0, sp0 - 16'd4});
    chk("R3 return address at SP-2", {16'd0, stk_mem[(sp0 - 16'd2) >> 1]}, {16'd0, ra});
    chk("R3 old page at SP-4", {16'd0, stk_mem[(sp0 - 16'd4) >> 1]}, {24'd0, pg0});
    chk("R8 phys fetch", {10'd0, phys_fetch}, {10'd0, exp_phys(e_tgt, e_pg)});
    chk("R8 window hit", {31'd0, win_hit}, {31'd0, (e_tgt[15:14] == 2'b10)});
    @(negedge clk);
    chk("R4 done one cycle", {31'd0, done}, 32'd0);
    chk(both ? "R9 call wins, no return queued" : "R7 idle after call",
        {31'd0, busy}, 32'd0);
    chk("R7 no extra sequence", {16'd0, sp_o}, {16'd0, sp0 - 16'd4});
    sh_pg[depth] = pg0;
    sh_ra[depth] = ra;
    depth++;
  endtask

  task automatic do_ret(input bit noise);
    logic [15:0] sp0;
    int k;
    sp0 = sp_o;
    depth--;
    ret_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ret_req = 1'b0;
    if (noise) begin call_req = 1'b1; call_indirect = 1'b0; end
    k = 1;
    while (!done && k < 40) begin
      @(negedge clk);
      call_req = 1'b0;
      k++;
    end
    chk("R6 return done cycle", k, 3);
    chk("R6 page restored", {24'd0, page_o}, {24'd0, sh_pg[depth]});
    chk("R6 return address restored", {16'd0, fetch_addr}, {16'd0, sh_ra[depth]});
    chk("R6 sp raised by 4", {16'd0, sp_o}, {16'd0, sp0 + 16'd4});
    chk("R8 phys after return", {10'd0, phys_fetch},
        {10'd0, exp_phys(sh_ra[depth], sh_pg[depth])});
    @(negedge clk);
    chk("R7 idle after return", {31'd0, busy}, 32'd0);
    chk("R7 stray call ignored", {16'd0, sp_o}, {16'd0, sp0 + 16'd4});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) stk_mem[i] = 16'h0000;
    rst_n = 1'b0;
    call_req = 0; call_indirect = 0; ret_req = 0;
    call_page = 0; call_target = 0; ptr_addr = 0; cur_pc = 0; instr_len = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 irq_block", {31'd0, irq_block}, 32'd0);
    chk("R1 page", {24'd0, page_o}, 32'd0);
    chk("R1 fetch", {16'd0, fetch_addr}, 32'd0);
    chk("R1 sp", {16'd0, sp_o}, 32'h0200);
    chk("R1 strobes", {29'd0, stk_we, stk_re, mem_rd_req}, 32'd0);

    // R10: strobes stay low while idle with no request
    repeat (3) begin
      @(negedge clk);
      chk("R10 quiet idle", {30'd0, stk_we, stk_re}, 32'd0);
    end

    // window boundaries, R8
    do_call(0, 8'h3C, 16'h7FFF, 16'h0, 16'h1000, 3'd4, 0, 0); do_ret(0);
    do_call(0, 8'hC3, 16'h8000, 16'h0, 16'h2000, 3'd3, 0, 0); do_ret(0);
    do_call(0, 8'h5A, 16'hBFFF, 16'h0, 16'h9000, 3'd2, 0, 0); do_ret(0);
    do_call(0, 8'hA5, 16'hC000, 16'h0, 16'hA000, 3'd5, 0, 0); do_ret(0);

    // sweep every page, mixing direct and indirect, nesting every fourth
    for (int p = 0; p < 256; p++) begin
      do_call(((p % 3) == 1), p[7:0], 16'(p * 263 + 31), 16'(p * 97 + 5),
              16'(p * 131 + 16'h8100), 3'((p % 5) + 1), ((p % 7) == 0), ((p % 11) == 0));
      if ((p % 4) != 3) do_ret(((p % 6) == 2));
    end
    while (depth > 0) do_ret(((depth % 5) == 0));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule